// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects request lines from eight devices and picks the one the processor should serve next. A rising edge on a request line marks that source pending. The processor raises a strobe at each instruction boundary. On that strobe, if interrupts are globally enabled and a pending source outranks every handler already running, the controller does four things at one clock edge:

- It pulses the acknowledge line of the chosen device for one cycle, so the device can withdraw its request.
- It returns the handler address stored for that source in a writable table.
- It latches the address of the interrupted instruction as the return point.
- It marks the source as in service.

Handlers can nest. A source with a lower index outranks one with a higher index, and it may pre-empt a running handler of lower rank. A source of lower or equal rank waits. When interrupts are disabled, pending sources are kept and are not lost. An end-of-handler pulse retires the highest-ranked in-service source. The next boundary strobe then considers whatever is still pending. Saving processor registers is left to the processor.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset, `irq_ack` and `in_svc` are all zero, `take` is 0, and `vec_addr` and `ret_pc` are zero.
- R2: A rising edge on `irq_req[i]` makes source i pending. A pending source is taken at a clock edge where `insn_bound` and `glb_en` are both 1. From the following cycle on, `take` is 1 and `irq_ack` is the one-hot value with bit i set. Both last exactly one cycle.
- R3: Without `insn_bound`, no source is taken, however long it has been pending.
- R4: While `glb_en` is 0, no source is taken and pending sources are kept. The first boundary strobe after re-enabling takes them.
- R5: When several sources are pending, the lowest index is taken first. The others are taken in ascending index order on later boundaries.
- R6: When a source is taken, `vec_addr` shows the table entry for that source and `ret_pc` shows `cur_pc` as sampled at the taking edge. A table write (`tbl_we`, `tbl_idx`, `tbl_wdata`) changes the address returned for later takes of that source.
- R7: A pending source whose index is lower than every set bit of `in_svc` pre-empts. It is taken and its bit is added to `in_svc`, while the bits already set stay set.
- R8: A pending source whose index is greater than the lowest set `in_svc` bit is not taken. It stays pending.
- R9: An `eoi` pulse clears the lowest-index set bit of `in_svc`. After that, waiting sources become eligible.
- R10: The pending bit of a taken source clears at the same edge that raises its acknowledge. A request line held high after acknowledge does not make the source pending again. The same line never acknowledges in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 8 | Device request lines; a rising edge marks a source pending |
| glb_en | input | 1 | Global interrupt enable |
| insn_bound | input | 1 | Instruction-boundary strobe from the processor |
| cur_pc | input | 32 | Address of the instruction to resume at |
| eoi | input | 1 | End-of-handler pulse |
| tbl_we | input | 1 | Vector table write enable |
| tbl_idx | input | 3 | Vector table entry index |
| tbl_wdata | input | 32 | Handler address to write |
| irq_ack | output | 8 | One-cycle acknowledge, one bit per device |
| take | output | 1 | One-cycle pulse: an interrupt has been taken |
| vec_addr | output | 32 | Handler address of the taken source |
| ret_pc | output | 32 | Captured return address |
| in_svc | output | 8 | In-service bits of the nested handlers |

## Verification
A request edge applied in cycle t is pending after the edge that closes t. The bench therefore drives requests for one cycle before it raises the boundary strobe. A take decided at a strobed edge appears on `take`, `irq_ack`, `vec_addr` and `ret_pc` in the very next cycle. The effect of an `eoi` shows on `in_svc` one edge after the pulse. The bench changes inputs on the falling clock edge and reads results on the next falling edge, exactly one registered stage after the decision, so every sample lands in the cycle each result is due.

// File: rtl/irqc_pkg.sv
// Shared constants for the interrupt controller.
// Assumes: source count is a power of two, or at least index width is derived from it.
package irqc_pkg;
    localparam int NSRC   = 8;
    localparam int ADDR_W = 32;
endpackage

// File: rtl/irqc_pick.sv
// Finds the lowest-index set bit of a vector (highest rank).
// Assumes: lower index means higher priority; output index is 0 when none set.
module irqc_pick #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    // Scan from the top so the lowest set index is the last written.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

    // Isolate the lowest set bit.
    assign onehot = bits & (~bits + N'(1));
endmodule

// File: rtl/irqc_pend.sv
// Edge detector and pending register, one bit per source.
// Assumes: devices hold requests until acknowledged; only rising edges register.
module irqc_pend #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] req_q;

    // Track request history and accumulate new edges, dropping granted bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= req;
            pend  <= (pend & ~clr) | (req & ~req_q);
        end
    end
endmodule

// File: rtl/irqc_vtable.sv
// Handler address table with one write port and one combinational read port.
// Assumes: a same-cycle write and read of one entry returns the old value.
module irqc_vtable #(
    parameter int N  = 8,
    parameter int AW = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [AW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [AW-1:0] rdata
);
    logic [AW-1:0] entry [N];

    // Clear every entry on reset, else store one address on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) entry[i] <= '0;
        end else if (we) begin
            entry[widx] <= wdata;
        end
    end

    // Read port used by the grant logic.
    assign rdata = entry[ridx];
endmodule

// File: rtl/irqc_top.sv
// Prioritised, nesting, vectored interrupt controller.
// Assumes: the processor strobes insn_bound once per instruction boundary and
// pulses eoi once per finished handler; lower source index outranks higher.
module irqc_top #(
    parameter int N_SRC  = irqc_pkg::NSRC,
    parameter int ADDR_W = irqc_pkg::ADDR_W,
    localparam int IW    = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_req,
    input  logic              glb_en,
    input  logic              insn_bound,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              eoi,
    input  logic              tbl_we,
    input  logic [IW-1:0]     tbl_idx,
    input  logic [ADDR_W-1:0] tbl_wdata,
    output logic [N_SRC-1:0]  irq_ack,
    output logic              take,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [ADDR_W-1:0] ret_pc,
    output logic [N_SRC-1:0]  in_svc
);
    logic [N_SRC-1:0]  pend, p_oh, s_oh, a_oh, svc_after, grant_oh;
    logic              p_any, s_any, a_any, grant;
    logic [IW-1:0]     p_idx, s_idx, a_idx;
    logic [ADDR_W-1:0] tbl_rd;

    irqc_pend #(.N(N_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(grant_oh), .pend(pend)
    );

    irqc_pick #(.N(N_SRC)) u_pick_pend (
        .bits(pend), .any(p_any), .idx(p_idx), .onehot(p_oh)
    );

    irqc_pick #(.N(N_SRC)) u_pick_svc (
        .bits(in_svc), .any(s_any), .idx(s_idx), .onehot(s_oh)
    );

    irqc_pick #(.N(N_SRC)) u_pick_after (
        .bits(svc_after), .any(a_any), .idx(a_idx), .onehot(a_oh)
    );

    irqc_vtable #(.N(N_SRC), .AW(ADDR_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx),
        .wdata(tbl_wdata), .ridx(p_idx), .rdata(tbl_rd)
    );

    // In-service set once this cycle's end-of-handler is applied.
    assign svc_after = (eoi && s_any) ? (in_svc & ~s_oh) : in_svc;

    // Grant when strobed, enabled, and the best pending outranks all running handlers.
    assign grant    = insn_bound && glb_en && p_any && (!a_any || (p_idx < a_idx));
    assign grant_oh = grant ? p_oh : '0;

    // Register the grant results and nesting state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_ack  <= '0;
            take     <= 1'b0;
            vec_addr <= '0;
            ret_pc   <= '0;
            in_svc   <= '0;
        end else begin
            irq_ack <= grant_oh;
            take    <= grant;
            in_svc  <= svc_after | grant_oh;
            if (grant) begin
                vec_addr <= tbl_rd;
                ret_pc   <= cur_pc;
            end
        end
    end
endmodule

// File: rtl/irqc_chk.sv
// Property checker for irqc_top, attached by bind below.
// Assumes: observes top-level ports only.
module irqc_chk #(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glb_en,
    input logic             insn_bound,
    input logic             eoi,
    input logic [N_SRC-1:0] irq_ack,
    input logic             take,
    input logic [N_SRC-1:0] in_svc
);
    assert_take_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($countones(irq_ack) == 1))
        else $error("take without single acknowledge");

    assert_ack_has_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack != '0) |-> take)
        else $error("acknowledge without take");

    assert_needs_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_bound |=> !take)
        else $error("take without boundary strobe");

    assert_disabled_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !take)
        else $error("take while disabled");

    assert_ack_in_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((in_svc & irq_ack) == irq_ack))
        else $error("taken source not in service");

    assert_eoi_retires_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (in_svc != '0) && !(insn_bound && glb_en))
        |=> ($countones(in_svc) + 1 == $past($countones(in_svc))))
        else $error("eoi did not retire exactly one handler");

    assert_ack_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack != '0) |=> ((irq_ack & $past(irq_ack)) == '0))
        else $error("acknowledge held two cycles");
endmodule

bind irqc_top irqc_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .insn_bound(insn_bound),
    .eoi(eoi), .irq_ack(irq_ack), .take(take), .in_svc(in_svc)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    typedef struct packed {
        logic [7:0]  mask;
        logic [31:0] pc;
    } stim_t;

    localparam stim_t STIM [0:5] = '{
        '{8'b0000_0001, 32'h0000_1000},
        '{8'b1000_0000, 32'h0000_2000},
        '{8'b0010_0100, 32'h0000_3000},
        '{8'b1111_1111, 32'h0000_4000},
        '{8'b0101_0000, 32'h0000_5000},
        '{8'b1000_0010, 32'h0000_6000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_req = '0;
    logic        glb_en = 1'b0;
    logic        insn_bound = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        eoi = 1'b0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_idx = '0;
    logic [31:0] tbl_wdata = '0;
    logic [7:0]  irq_ack;
    logic        take;
    logic [31:0] vec_addr, ret_pc;
    logic [7:0]  in_svc;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] tbl_exp [N];

    irqc_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .glb_en(glb_en),
        .insn_bound(insn_bound), .cur_pc(cur_pc), .eoi(eoi), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata), .irq_ack(irq_ack), .take(take),
        .vec_addr(vec_addr), .ret_pc(ret_pc), .in_svc(in_svc)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // Pulse a request mask for one cycle, then release it.
    task automatic pulse_req(input logic [7:0] m);
        irq_req = m;
        cyc();
        irq_req = '0;
    endtask

    // Strobe one boundary; outputs are checked on the following negedge.
    task automatic strobe(input logic [31:0] pc);
        insn_bound = 1'b1;
        cur_pc = pc;
        cyc();
        insn_bound = 1'b0;
    endtask

    task automatic end_handler();
        eoi = 1'b1;
        cyc();
        eoi = 1'b0;
    endtask

    task automatic expect_take(input string tag, input int src, input logic [31:0] pc);
        check({tag, " take"}, 32'(take), 32'd1);
        check({tag, " ack"}, 32'(irq_ack), 32'(8'b1 << src));
        check({tag, " vec"}, vec_addr, tbl_exp[src]);
        check({tag, " ret"}, ret_pc, pc);
    endtask

    function automatic int low_idx(input logic [7:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return -1;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc();
        cyc();
        // R1 reset state
        check("R1 ack", 32'(irq_ack), 32'd0);
        check("R1 take", 32'(take), 32'd0);
        check("R1 in_svc", 32'(in_svc), 32'd0);
        check("R1 vec", vec_addr, 32'd0);
        check("R1 ret", ret_pc, 32'd0);
        rst_n = 1'b1;

        // Fill the table (R6)
        for (int i = 0; i < N; i++) begin
            tbl_exp[i] = 32'h0000_8000 + 32'(i) * 32'h100;
            tbl_we = 1'b1;
            tbl_idx = 3'(i);
            tbl_wdata = tbl_exp[i];
            cyc();
        end
        tbl_we = 1'b0;
        glb_en = 1'b1;

        // Table walk: R2 and R5 ascending order, R9 drains, R6 vectors
        for (int v = 0; v < 6; v++) begin
            logic [7:0] rem;
            int k;
            rem = STIM[v].mask;
            k = 0;
            pulse_req(rem);
            while (rem != '0) begin
                int w;
                w = low_idx(rem);
                strobe(STIM[v].pc + 32'(k));
                expect_take($sformatf("R5 v%0d", v), w, STIM[v].pc + 32'(k));
                cyc();
                check("R2 single pulse", 32'(take), 32'd0);
                end_handler();
                rem[w] = 1'b0;
                k++;
            end
            strobe(32'hFFFF_0000);
            check("R10 no retake", 32'(take), 32'd0);
        end

        // R3: no strobe, no take
        pulse_req(8'b0000_1000);
        repeat (4) cyc();
        check("R3 no strobe", 32'(take), 32'd0);
        strobe(32'h100);
        expect_take("R3 late", 3, 32'h100);
        end_handler();

        // R4: disabled holds pending
        glb_en = 1'b0;
        pulse_req(8'b0001_0000);
        strobe(32'h200);
        check("R4 disabled", 32'(take), 32'd0);
        cyc();
        glb_en = 1'b1;
        strobe(32'h204);
        expect_take("R4 reenabled", 4, 32'h204);
        end_handler();

        // R7 nesting, R8 waiting, R9 retire order
        pulse_req(8'b0010_0000);
        strobe(32'h300);
        expect_take("R7 outer", 5, 32'h300);
        pulse_req(8'b0000_0100);
        strobe(32'h304);
        expect_take("R7 preempt", 2, 32'h304);
        check("R7 in_svc", 32'(in_svc), 32'h24);
        pulse_req(8'b0100_0000);
        strobe(32'h308);
        check("R8 lower waits", 32'(take), 32'd0);
        end_handler();
        check("R9 first eoi", 32'(in_svc), 32'h20);
        strobe(32'h30C);
        check("R8 still waits", 32'(take), 32'd0);
        end_handler();
        check("R9 second eoi", 32'(in_svc), 32'h00);
        strobe(32'h310);
        expect_take("R9 released", 6, 32'h310);
        end_handler();

        // R10: held request acked once, not re-pended
        irq_req = 8'b0000_1000;
        cyc();
        strobe(32'h400);
        expect_take("R10 held", 3, 32'h400);
        cyc();
        check("R10 ack one cycle", 32'(irq_ack), 32'd0);
        end_handler();
        strobe(32'h404);
        check("R10 held no repend", 32'(take), 32'd0);
        irq_req = '0;
        cyc();

        // R6: rewrite an entry
        tbl_exp[6] = 32'hCAFE_0600;
        tbl_we = 1'b1;
        tbl_idx = 3'd6;
        tbl_wdata = tbl_exp[6];
        cyc();
        tbl_we = 1'b0;
        pulse_req(8'b0100_0000);
        strobe(32'h500);
        expect_take("R6 rewritten", 6, 32'h500);
        end_handler();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule